// File: doc/BRIEF.md
# UART Channel Modem Control and Interrupt Pin Logic

This block is the per-channel handshake front end of a UART. A CPU register port writes three registers: a modem control byte, an interrupt enable nibble and a modem status byte, which is read-only. From these registers the block drives the active-low data-terminal-ready and request-to-send pins, a general-purpose user output, and the channel interrupt pin. The interrupt pin is presented as a level plus a three-state drive enable, so the pad ring can build the pin from them.

The four active-low modem inputs (clear-to-send, data-set-ready, ring indicate, carrier detect) each pass through a synchronizer. Their asserted levels are shown in the status register. A change on an input sets a sticky delta bit, and a CPU read of the status register clears the delta bits. Any pending delta acts as the modem-status interrupt source. A loopback control bit turns the channel back on itself: the transmit serial stream feeds the receiver, and the external receive line is ignored.

Top module: `mdm_ctl_chan`

## Requirements
- R1: After synchronous active-high reset, dtr_out_n, rts_out_n and usr_out are 1, irq_drive and irq_level are 0, and reads of addresses 1, 4 and 6 return 0.
- R2: Modem control is at address 4. Bit 0 drives dtr_out_n to the inverse of its value, and the write takes effect on the clock edge that samples reg_wr_n low.
- R3: Modem control bit 1 drives rts_out_n to the inverse of its value.
- R4: When modem control bit 3 is 1, irq_drive is 1 and usr_out is 0. When bit 3 is 0, irq_drive is 0 and usr_out is 1.
- R5: irq_level is 1 exactly when modem control bit 3 is 1 and at least one enabled source is pending. The interrupt enable register is at address 1, with these bits: 0 received data, 1 transmit empty, 2 line error, 3 modem status.
- R6: Status register bits 7:4 show the asserted (pin low) level of carrier detect, ring indicate, data-set-ready and clear-to-send, in that order from bit 7 down to bit 4. A pin change appears there two clocks after the pin is sampled.
- R7: Status bits 3, 1 and 0 (carrier detect, data-set-ready, clear-to-send) set on any change of their input. Bit 2 sets only when the ring indicate pin goes from low to high. Each delta appears one clock after the new level.
- R8: A clock edge that samples reg_rd_n low at address 6 clears all delta bits, except a delta that sets on that same edge, which is kept.
- R9: With modem control bit 4 set, rx_ser_out follows tx_ser_in and tx_line_out is held at 1, whatever rx_line_in does. With bit 4 clear, rx_ser_out follows rx_line_in and tx_line_out follows tx_ser_in.
- R10: Only modem control bits 4:0 and enable bits 3:0 are stored, and the other bits read 0. Writes to any address other than 1 and 4 change no register. Addresses other than 1, 4 and 6 read 0.
- R11: The modem-status interrupt source is pending while any delta bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr_n | input | 1 | Write strobe, active low, one cycle |
| reg_rd_n | input | 1 | Read strobe, active low, one cycle |
| reg_rdata | output | 8 | Read data for reg_addr |
| cts_in_n | input | 1 | Clear-to-send pin, active low |
| dsr_in_n | input | 1 | Data-set-ready pin, active low |
| ri_in_n | input | 1 | Ring indicate pin, active low |
| dcd_in_n | input | 1 | Carrier detect pin, active low |
| rx_data_pend | input | 1 | Received-data interrupt condition |
| tx_empty_pend | input | 1 | Transmit-empty interrupt condition |
| line_err_pend | input | 1 | Receive line error interrupt condition |
| tx_ser_in | input | 1 | Serial data from the transmitter |
| rx_line_in | input | 1 | External receive line |
| rx_ser_out | output | 1 | Serial data to the receiver |
| tx_line_out | output | 1 | External transmit line |
| dtr_out_n | output | 1 | Data-terminal-ready pin, active low |
| rts_out_n | output | 1 | Request-to-send pin, active low |
| usr_out | output | 1 | User output pin |
| irq_level | output | 1 | Interrupt pin level, active high |
| irq_drive | output | 1 | Interrupt pin drive enable (0 = high impedance) |

## Verification
The bench samples the status register at exactly two and three clocks after each pin change. A synchronizer that is one stage too short or too long therefore shows up as a level or delta that is early or late. Ring indicate is driven in both directions: a design that flags the falling pin edge, or any change at all, sets bit 2 when it must stay clear. A read strobe is placed on the same edge on which a new delta lands, to catch a clear that wins over the set and loses an event. Every value of the control byte, and every combination of enables, pending sources and the pin-enable bit, is swept to expose swapped bits, a wrong polarity, or an interrupt that leaks out while the pin floats.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 8;
    localparam int MODEM_N = 4;

    localparam logic [ADDR_W-1:0] A_IEN   = 3'd1;
    localparam logic [ADDR_W-1:0] A_MCTL  = 3'd4;
    localparam logic [ADDR_W-1:0] A_MSTAT = 3'd6;

    // modem line index inside the 4-bit vectors
    localparam int L_CTS = 0;
    localparam int L_DSR = 1;
    localparam int L_RI  = 2;
    localparam int L_DCD = 3;

    typedef struct packed {
        logic loop_en;  // bit 4
        logic pin_en;   // bit 3
        logic spare;    // bit 2
        logic rts;      // bit 1
        logic dtr;      // bit 0
    } mctl_t;

    typedef struct packed {
        logic modem;     // bit 3
        logic line_err;  // bit 2
        logic tx_empty;  // bit 1
        logic rx_data;   // bit 0
    } ien_t;

    typedef struct packed {
        logic [MODEM_N-1:0] level;
        logic [MODEM_N-1:0] delta;
    } mstat_t;

    localparam int MCTL_W = $bits(mctl_t);
    localparam int IEN_W  = $bits(ien_t);

    // widen a narrow register to the bus width, upper bits zero
    function automatic logic [DATA_W-1:0] pad_mctl(input mctl_t m);
        return {{(DATA_W-MCTL_W){1'b0}}, m};
    endfunction

    function automatic logic [DATA_W-1:0] pad_ien(input ien_t e);
        return {{(DATA_W-IEN_W){1'b0}}, e};
    endfunction

endpackage

// File: rtl/mdm_regs.sv
module mdm_regs
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_n,
    input  logic              rd_n,
    input  mstat_t            mstat,
    output mctl_t             mctl,
    output ien_t              ien,
    output logic [DATA_W-1:0] rdata,
    output logic              stat_rd
);

    logic wr_mctl;
    logic wr_ien;

    assign wr_mctl = !wr_n && (addr == A_MCTL);
    assign wr_ien  = !wr_n && (addr == A_IEN);
    assign stat_rd = !rd_n && (addr == A_MSTAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            mctl <= '0;
            ien  <= '0;
        end else begin
            if (wr_mctl) mctl <= mctl_t'(wdata[MCTL_W-1:0]);
            if (wr_ien)  ien  <= ien_t'(wdata[IEN_W-1:0]);
        end
    end

    always_comb begin
        unique case (addr)
            A_IEN:   rdata = pad_ien(ien);
            A_MCTL:  rdata = pad_mctl(mctl);
            A_MSTAT: rdata = mstat;
            default: rdata = '0;
        endcase
    end

    // R2: control write lands on the next edge
    assert_mctl_write_R2: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && addr == A_MCTL) |=> (mctl == mctl_t'($past(wdata[MCTL_W-1:0]))));

    // R10: writes elsewhere leave the enable register alone
    assert_ien_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_n || addr != A_IEN) |=> $stable(ien));

endmodule

// File: rtl/mdm_status.sv
module mdm_status
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
)(
    input  logic               clk,
    input  logic               rst,
    input  logic [MODEM_N-1:0] pins_n,
    input  logic               rd_clr,
    output mstat_t             mstat,
    output logic               delta_any
);

    localparam int CHAIN_W = SYNC_STAGES * MODEM_N;

    logic [CHAIN_W-1:0] chain;
    logic [MODEM_N-1:0] now_a;
    logic [MODEM_N-1:0] prev_a;
    logic [MODEM_N-1:0] edges;
    logic [MODEM_N-1:0] delta_q;

    // pins idle high: reset the chain to the deasserted value
    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[CHAIN_W-MODEM_N-1:0], pins_n};
    end

    assign now_a = ~chain[CHAIN_W-1 -: MODEM_N];

    always_ff @(posedge clk) begin
        if (rst) prev_a <= '0;
        else     prev_a <= now_a;
    end

    for (genvar i = 0; i < MODEM_N; i++) begin : g_edge
        if (i == L_RI) begin : g_trail
            assign edges[i] = prev_a[i] && !now_a[i];
        end else begin : g_any
            assign edges[i] = prev_a[i] ^ now_a[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         delta_q <= '0;
        else if (rd_clr) delta_q <= edges;
        else             delta_q <= delta_q | edges;
    end

    assign mstat.level = now_a;
    assign mstat.delta = delta_q;
    assign delta_any   = |delta_q;

    // R8: read clears deltas when no new edge arrives
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && edges == '0) |=> (mstat.delta == '0));

    // R7: ring indicate release sets its delta
    assert_ri_trail_R7: assert property (@(posedge clk) disable iff (rst)
        (prev_a[L_RI] && !now_a[L_RI]) |=> mstat.delta[L_RI]);

    // R7: ring indicate assertion never sets its delta by itself
    assert_ri_lead_R7: assert property (@(posedge clk) disable iff (rst)
        (!mstat.delta[L_RI] && !(prev_a[L_RI] && !now_a[L_RI])) |=> !mstat.delta[L_RI]);

endmodule

// File: rtl/mdm_pins.sv
module mdm_pins
    import mdm_pkg::*;
(
    input  mctl_t mctl,
    input  ien_t  ien,
    input  logic  rx_data_pend,
    input  logic  tx_empty_pend,
    input  logic  line_err_pend,
    input  logic  modem_pend,
    input  logic  tx_ser_in,
    input  logic  rx_line_in,
    output logic  rx_ser_out,
    output logic  tx_line_out,
    output logic  dtr_out_n,
    output logic  rts_out_n,
    output logic  usr_out,
    output logic  irq_level,
    output logic  irq_drive
);

    ien_t pend;
    logic any_src;

    assign pend.rx_data  = rx_data_pend;
    assign pend.tx_empty = tx_empty_pend;
    assign pend.line_err = line_err_pend;
    assign pend.modem    = modem_pend;

    assign any_src = |(ien & pend);

    assign dtr_out_n = !mctl.dtr;
    assign rts_out_n = !mctl.rts;

    // one bit swaps the user pin and the interrupt pin drive together
    assign irq_drive = mctl.pin_en;
    assign usr_out   = !mctl.pin_en;
    assign irq_level = mctl.pin_en && any_src;

    assign rx_ser_out  = mctl.loop_en ? tx_ser_in : rx_line_in;
    assign tx_line_out = mctl.loop_en ? 1'b1      : tx_ser_in;

endmodule

// File: rtl/mdm_ctl_chan.sv
module mdm_ctl_chan
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr_n,
    input  logic              reg_rd_n,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cts_in_n,
    input  logic              dsr_in_n,
    input  logic              ri_in_n,
    input  logic              dcd_in_n,
    input  logic              rx_data_pend,
    input  logic              tx_empty_pend,
    input  logic              line_err_pend,
    input  logic              tx_ser_in,
    input  logic              rx_line_in,
    output logic              rx_ser_out,
    output logic              tx_line_out,
    output logic              dtr_out_n,
    output logic              rts_out_n,
    output logic              usr_out,
    output logic              irq_level,
    output logic              irq_drive
);

    mctl_t              mctl;
    ien_t               ien;
    mstat_t             mstat;
    logic               stat_rd;
    logic               delta_any;
    logic [MODEM_N-1:0] pins_n;

    always_comb begin
        pins_n        = '1;
        pins_n[L_CTS] = cts_in_n;
        pins_n[L_DSR] = dsr_in_n;
        pins_n[L_RI]  = ri_in_n;
        pins_n[L_DCD] = dcd_in_n;
    end

    mdm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .wr_n    (reg_wr_n),
        .rd_n    (reg_rd_n),
        .mstat   (mstat),
        .mctl    (mctl),
        .ien     (ien),
        .rdata   (reg_rdata),
        .stat_rd (stat_rd)
    );

    mdm_status #(.SYNC_STAGES(SYNC_STAGES)) u_status (
        .clk       (clk),
        .rst       (rst),
        .pins_n    (pins_n),
        .rd_clr    (stat_rd),
        .mstat     (mstat),
        .delta_any (delta_any)
    );

    mdm_pins u_pins (
        .mctl          (mctl),
        .ien           (ien),
        .rx_data_pend  (rx_data_pend),
        .tx_empty_pend (tx_empty_pend),
        .line_err_pend (line_err_pend),
        .modem_pend    (delta_any),
        .tx_ser_in     (tx_ser_in),
        .rx_line_in    (rx_line_in),
        .rx_ser_out    (rx_ser_out),
        .tx_line_out   (tx_line_out),
        .dtr_out_n     (dtr_out_n),
        .rts_out_n     (rts_out_n),
        .usr_out       (usr_out),
        .irq_level     (irq_level),
        .irq_drive     (irq_drive)
    );

    // R4: writing the pin-enable bit swaps both pins on the next edge
    assert_pin_swap_R4: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr_n && reg_addr == A_MCTL && reg_wdata[3]) |=> (irq_drive && !usr_out));

    // R5: a floating interrupt pin never carries an active level
    assert_irq_gate_R5: assert property (@(posedge clk) disable iff (rst)
        !irq_drive |-> !irq_level);

    // R11: a pending delta with modem source enabled raises the interrupt
    assert_modem_src_R11: assert property (@(posedge clk) disable iff (rst)
        (delta_any && ien.modem && mctl.pin_en) |-> irq_level);

endmodule

// File: tb/mdm_ctl_chan_test.sv
module mdm_ctl_chan_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr_n = 1'b1;
    logic       reg_rd_n = 1'b1;
    logic [7:0] reg_rdata;
    logic [3:0] pin_n = 4'hF;   // 0 cts, 1 dsr, 2 ri, 3 dcd
    logic       rx_data_pend = 1'b0;
    logic       tx_empty_pend = 1'b0;
    logic       line_err_pend = 1'b0;
    logic       tx_ser_in = 1'b1;
    logic       rx_line_in = 1'b1;
    logic       rx_ser_out, tx_line_out, dtr_out_n, rts_out_n;
    logic       usr_out, irq_level, irq_drive;

    int n_chk = 0;
    int n_err = 0;
    logic [3:0] m_lvl = '0;
    logic [3:0] m_dlt = '0;

    always #10 clk = ~clk;   // 50 MHz

    mdm_ctl_chan uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr_n(reg_wr_n), .reg_rd_n(reg_rd_n), .reg_rdata(reg_rdata),
        .cts_in_n(pin_n[0]), .dsr_in_n(pin_n[1]), .ri_in_n(pin_n[2]), .dcd_in_n(pin_n[3]),
        .rx_data_pend(rx_data_pend), .tx_empty_pend(tx_empty_pend),
        .line_err_pend(line_err_pend), .tx_ser_in(tx_ser_in), .rx_line_in(rx_line_in),
        .rx_ser_out(rx_ser_out), .tx_line_out(tx_line_out), .dtr_out_n(dtr_out_n),
        .rts_out_n(rts_out_n), .usr_out(usr_out), .irq_level(irq_level), .irq_drive(irq_drive)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_n = 1'b0;
        @(negedge clk);
        reg_wr_n = 1'b1;
    endtask

    // sample without a read strobe (no side effect)
    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // read with strobe: clears the delta bits at address 6
    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd_n = 1'b0;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd_n = 1'b1;
        if (a == 3'd6) m_dlt = '0;
    endtask

    // change one modem pin, check level at +2 clocks and delta at +3
    task automatic pin_step(input int idx, input logic v);
        logic [7:0] d;
        logic old_a;
        old_a = m_lvl[idx];
        @(negedge clk);
        pin_n[idx] = v;
        @(negedge clk);
        @(negedge clk);
        m_lvl[idx] = ~v;
        peek(3'd6, d);
        chk("R6 level after two clocks", d, {m_lvl, m_dlt});
        @(negedge clk);
        if (idx == 2) begin
            if (old_a && v) m_dlt[idx] = 1'b1;
        end else if (old_a != ~v) begin
            m_dlt[idx] = 1'b1;
        end
        peek(3'd6, d);
        chk("R7 delta after three clocks", d, {m_lvl, m_dlt});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 dtr", dtr_out_n, 1);
        chk("R1 rts", rts_out_n, 1);
        chk("R1 usr", usr_out, 1);
        chk("R1 drive", irq_drive, 0);
        chk("R1 level", irq_level, 0);
        peek(3'd1, d); chk("R1 ien", d, 0);
        peek(3'd4, d); chk("R1 mctl", d, 0);
        peek(3'd6, d); chk("R1 mstat", d, 0);

        // R2 R3 R4 R10: sweep every control byte
        for (int v = 0; v < 256; v++) begin
            wr(3'd4, 8'(v));
            peek(3'd4, d);
            chk("R10 mctl readback", d, v & 8'h1F);
            chk("R2 dtr", dtr_out_n, ((v >> 0) & 1) ^ 1);
            chk("R3 rts", rts_out_n, ((v >> 1) & 1) ^ 1);
            chk("R4 drive", irq_drive, (v >> 3) & 1);
            chk("R4 usr", usr_out, ((v >> 3) & 1) ^ 1);
        end

        // R5: enables x pending x pin-enable
        for (int oe = 0; oe < 2; oe++) begin
            wr(3'd4, 8'(oe << 3));
            for (int ie = 0; ie < 16; ie++) begin
                wr(3'd1, 8'(ie | 8'hF0));
                peek(3'd1, d);
                chk("R10 ien readback", d, ie);
                for (int p = 0; p < 8; p++) begin
                    @(negedge clk);
                    rx_data_pend = p[0]; tx_empty_pend = p[1]; line_err_pend = p[2];
                    #1 chk("R5 irq gate", irq_level, (oe != 0 && ((ie & p & 7) != 0)) ? 1 : 0);
                end
            end
        end
        rx_data_pend = 0; tx_empty_pend = 0; line_err_pend = 0;

        // R10: writes to other addresses change nothing, reads return zero
        wr(3'd4, 8'h0B);
        wr(3'd1, 8'h05);
        for (int a = 0; a < 8; a++) begin
            if (a != 1 && a != 4) wr(3'(a), 8'hFF);
        end
        peek(3'd4, d); chk("R10 mctl kept", d, 8'h0B);
        peek(3'd1, d); chk("R10 ien kept", d, 8'h05);
        for (int a = 0; a < 8; a++) begin
            if (a != 1 && a != 4 && a != 6) begin
                peek(3'(a), d); chk("R10 unused read", d, 0);
            end
        end

        // R6 R7: toggle each modem pin both ways
        for (int i = 0; i < 4; i++) begin
            pin_step(i, 1'b0);
            pin_step(i, 1'b1);
        end
        rd(3'd6, d);
        peek(3'd6, d); chk("R8 cleared by read", d, 0);

        // ring indicate: assertion alone sets no delta, release does
        pin_step(2, 1'b0);
        peek(3'd6, d); chk("R7 ri lead no delta", d[2], 0);
        pin_step(2, 1'b1);
        peek(3'd6, d); chk("R7 ri trail delta", d[2], 1);
        rd(3'd6, d);

        // R11: modem source through to the pin
        wr(3'd1, 8'h08);
        wr(3'd4, 8'h08);
        @(negedge clk); chk("R11 no delta no irq", irq_level, 0);
        pin_step(0, 1'b0);
        chk("R11 delta raises irq", irq_level, 1);
        rd(3'd6, d);
        #1 chk("R11 cleared drops irq", irq_level, 0);

        // R8: clear and new delta on the same edge
        pin_step(1, 1'b0);
        @(negedge clk);
        pin_n[3] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        reg_addr = 3'd6; reg_rd_n = 1'b0;
        @(negedge clk);
        reg_rd_n = 1'b1;
        peek(3'd6, d);
        chk("R8 same-edge delta kept", d, 8'hB8);

        // R9: loopback routing
        for (int lp = 0; lp < 2; lp++) begin
            wr(3'd4, 8'(lp << 4));
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                tx_ser_in = c[0]; rx_line_in = c[1];
                #1;
                chk("R9 rx path", rx_ser_out, lp ? c[0] : c[1]);
                chk("R9 tx line", tx_line_out, lp ? 1 : c[0]);
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule